// File: doc/BRIEF.md
# Conversion result register bank

This block holds the latest conversion result for each channel of an analog-to-digital converter. Software reads these results through a simple word-addressed register port. A sequencer reports each finished conversion with a one-cycle strobe. The strobe carries the channel number, the result code and a flag that says whether the converter is running in burst mode. The bank stores the result in that channel's data register and marks it as fresh. If a fresh result is replaced in burst mode before software reads it, the bank marks the loss.

Reading a channel's data register returns its contents and clears both of its flags. A separate interrupt-enable register decides what drives the single, level-sensitive interrupt output. One bit in it selects the mode. In per-channel mode, the fresh flags of the enabled channels drive the line. In global mode, a shared flag drives the line. Any completion sets the shared flag, and any data-register read clears it.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every data register reads 0, the interrupt-enable register reads 0x100 and `irq` is 0.
- R2: A completion strobe on channel n stores the result in bits 15:4 of data register n (word offset n) and sets its fresh flag (bit 31). Other channels are not changed.
- R3: A read of data register n puts its contents on `bus_rdata` one cycle later. The read clears bit 31 and bit 30 of that register but keeps the stored result.
- R4: A completion in burst mode on a channel whose bit 31 is already 1, and which is not being read in the same cycle, sets bit 30 (lost result).
- R5: A completion outside burst mode never sets bit 30, even when bit 31 is already 1.
- R6: When a read and a completion hit the same channel in the same cycle, the read returns the old contents. Afterwards bit 31 is 1, bit 30 is 0 and the new result is stored.
- R7: The interrupt-enable register sits at word offset 8. Bits 8:0 are writable and read back. Bits 31:9 read 0.
- R8: While enable bit 8 is 0, `irq` is 1 exactly when some channel n has bit 31 set and enable bit n set.
- R9: While enable bit 8 is 1, the enables in bits 7:0 are ignored. `irq` follows a shared flag. Any completion sets the flag, and a read of any data register clears it.
- R10: Writes to data registers have no effect. Reserved bits of the data registers read 0. Offsets 9 to 15 read 0.
- R11: The result codes 0x000 and 0xFFF are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpl_valid | input | 1 | One-cycle conversion-complete strobe |
| cpl_ch | input | 3 | Channel of the finished conversion |
| cpl_result | input | 12 | Result code of the finished conversion |
| cpl_burst | input | 1 | Converter is in burst mode |
| bus_addr | input | 4 | Word offset of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives a read and a burst completion on the same channel in the same cycle. A design that lets the clear win would lose the fresh flag, and one that counts the overwrite as a loss would wrongly set bit 30. Repeated completions are tested both with and without burst. A design that ignores the mode bit would raise bit 30 on ordinary overwrites, or miss it in burst. In global mode the bench reads a channel other than the one that completed, and it tests with all per-channel enables cleared. This catches an interrupt that stays tied to the per-channel flags. Writes to data registers and reads of unmapped offsets would expose any decode that corrupts stored results or leaks data into reserved bits.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned FRESH_B  = 31;
    localparam int unsigned LOST_B   = 30;
    localparam int unsigned CODE_LSB = 4;

    typedef enum logic {
        IRQ_PER_CH = 1'b0,
        IRQ_SHARED = 1'b1
    } irq_mode_e;

endpackage

// File: rtl/adc_rb_channel.sv
module adc_rb_channel #(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpl_hit,
    input  logic             burst,
    input  logic             rd_hit,
    input  logic [RES_W-1:0] res_in,
    output logic             fresh,
    output logic             lost,
    output logic [RES_W-1:0] code
);

    typedef struct packed {
        logic             fresh;
        logic             lost;
        logic [RES_W-1:0] code;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hit) begin
            st_d.fresh = 1'b0;
            st_d.lost  = 1'b0;
        end
        if (cpl_hit) begin
            st_d.code  = res_in;
            st_d.fresh = 1'b1;
            if (burst && st_q.fresh && !rd_hit) begin
                st_d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fresh = st_q.fresh;
    assign lost  = st_q.lost;
    assign code  = st_q.code;

    assert_fresh_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_hit |=> fresh);
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !cpl_hit) |=> (!fresh && !lost && $stable(code)));
    assert_burst_loss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_hit && burst && fresh && !rd_hit) |=> lost);
    assert_no_loss_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_hit && !burst && !lost) |=> !lost);
    assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_hit && rd_hit) |=> (fresh && !lost));

endmodule

// File: rtl/adc_rb_irq.sv
module adc_rb_irq
    import adc_rb_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_cpl,
    input  logic              any_rd,
    input  irq_mode_e         mode,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_fresh,
    output logic              irq
);

    typedef struct packed {
        logic shared_done;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (any_rd) begin
            st_d.shared_done = 1'b0;
        end
        if (any_cpl) begin
            st_d.shared_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = (mode == IRQ_SHARED) ? st_q.shared_done : |(ch_fresh & ch_en);

    assert_shared_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cpl && mode == IRQ_SHARED && $stable(mode)) |=> irq);
    assert_shared_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rd && !any_cpl && mode == IRQ_SHARED) |=> (mode != IRQ_SHARED || !irq));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_rb_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RES_W  = 12,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic [CH_W-1:0]   cpl_ch,
    input  logic [RES_W-1:0]  cpl_result,
    input  logic              cpl_burst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned IEN_W    = NUM_CH + 1;
    localparam int unsigned IEN_ADDR = NUM_CH;
    localparam logic [IEN_W-1:0] IEN_RST = IEN_W'(1) << NUM_CH;

    typedef struct packed {
        logic [IEN_W-1:0]  ien;
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_CH-1:0] ch_fresh;
    logic [NUM_CH-1:0] ch_lost;
    logic [RES_W-1:0]  ch_code [NUM_CH];
    logic              any_rd;
    logic              ien_sel;
    irq_mode_e         irq_mode;

    assign any_rd   = bus_rd && (bus_addr < ADDR_W'(NUM_CH));
    assign ien_sel  = (bus_addr == ADDR_W'(IEN_ADDR));
    assign irq_mode = irq_mode_e'(st_q.ien[NUM_CH]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        adc_rb_channel #(.RES_W(RES_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cpl_hit (cpl_valid && (cpl_ch == CH_W'(i))),
            .burst   (cpl_burst),
            .rd_hit  (bus_rd && (bus_addr == ADDR_W'(i))),
            .res_in  (cpl_result),
            .fresh   (ch_fresh[i]),
            .lost    (ch_lost[i]),
            .code    (ch_code[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr && ien_sel) begin
            st_d.ien = bus_wdata[IEN_W-1:0];
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            if (ien_sel) begin
                st_d.rdata[IEN_W-1:0] = st_q.ien;
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(i)) begin
                    st_d.rdata[FRESH_B]               = ch_fresh[i];
                    st_d.rdata[LOST_B]                = ch_lost[i];
                    st_d.rdata[CODE_LSB +: RES_W]     = ch_code[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ien   <= IEN_RST;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    adc_rb_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_cpl  (cpl_valid),
        .any_rd   (any_rd),
        .mode     (irq_mode),
        .ch_en    (st_q.ien[NUM_CH-1:0]),
        .ch_fresh (ch_fresh),
        .irq      (irq)
    );

    assign bus_rdata = st_q.rdata;

    assert_ien_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ien_sel) |=> (st_q.ien == $past(bus_wdata[IEN_W-1:0])));
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ien == '0) |-> !irq);
    assert_data_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ien_sel && !bus_rd && !cpl_valid) |=> $stable(ch_fresh) && $stable(ch_lost));

endmodule

// File: tb/adc_result_bank_tb.sv
`timescale 1ns/1ps
module adc_result_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_ch = '0;
    logic [11:0] cpl_result = '0;
    logic        cpl_burst = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    adc_result_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ch(cpl_ch),
        .cpl_result(cpl_result), .cpl_burst(cpl_burst), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] word(input logic f, input logic l, input logic [11:0] c);
        return {f, l, 14'b0, c, 4'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic complete(input int ch, input logic [11:0] val, input logic burst);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_ch = 3'(ch); cpl_result = val; cpl_burst = burst;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_burst = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(addr);
        @(negedge clk);
        bus_rd = 1'b0;
        data = bus_rdata;
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", 32'(irq), 32'd0);
        rd(8, d);
        check("R1 enable reset", d, 32'h100);
        for (int i = 0; i < 8; i++) begin
            rd(i, d);
            check("R1 data reset", d, 32'h0);
        end
    endtask

    task automatic t_latch();
        logic [31:0] d;
        complete(3, 12'hABC, 1'b0);
        rd(2, d);
        check("R2 neighbour untouched", d, 32'h0);
        rd(3, d);
        check("R2 stored with fresh flag", d, word(1, 0, 12'hABC));
        rd(3, d);
        check("R3 flags cleared result kept", d, word(0, 0, 12'hABC));
    endtask

    task automatic t_boundary();
        logic [31:0] d;
        complete(0, 12'h000, 1'b0);
        complete(7, 12'hFFF, 1'b0);
        rd(0, d);
        check("R11 zero code", d, word(1, 0, 12'h000));
        rd(7, d);
        check("R11 full-scale code", d, word(1, 0, 12'hFFF));
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        complete(5, 12'h123, 1'b1);
        complete(5, 12'h456, 1'b1);
        rd(5, d);
        check("R4 burst overwrite flags loss", d, word(1, 1, 12'h456));
        rd(5, d);
        check("R3 loss flag cleared by read", d, word(0, 0, 12'h456));
    endtask

    task automatic t_no_overrun();
        logic [31:0] d;
        complete(1, 12'h321, 1'b0);
        complete(1, 12'h654, 1'b0);
        rd(1, d);
        check("R5 single-mode overwrite no loss", d, word(1, 0, 12'h654));
    endtask

    task automatic t_collide();
        logic [31:0] d;
        complete(2, 12'h111, 1'b0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'd2;
        cpl_valid = 1'b1; cpl_ch = 3'd2; cpl_result = 12'h222; cpl_burst = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; cpl_valid = 1'b0; cpl_burst = 1'b0;
        check("R6 read returns old contents", bus_rdata, word(1, 0, 12'h111));
        rd(2, d);
        check("R6 new completion wins", d, word(1, 0, 12'h222));
    endtask

    task automatic t_enable_reg();
        logic [31:0] d;
        wr(8, 32'hFFFF_FFFF);
        rd(8, d);
        check("R7 writable bits only", d, 32'h1FF);
        wr(8, 32'h0);
        rd(8, d);
        check("R7 cleared", d, 32'h0);
    endtask

    task automatic t_per_channel();
        logic [31:0] d;
        wr(8, 32'h010);
        complete(3, 12'h00A, 1'b0);
        check("R8 disabled channel no irq", 32'(irq), 32'd0);
        complete(4, 12'h00B, 1'b0);
        check("R8 enabled channel irq", 32'(irq), 32'd1);
        rd(4, d);
        check("R8 irq drops after read", 32'(irq), 32'd0);
        rd(3, d);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        wr(8, 32'h1FF);
        check("R9 no irq before completion", 32'(irq), 32'd0);
        complete(6, 12'h0C0, 1'b0);
        check("R9 completion raises irq", 32'(irq), 32'd1);
        rd(0, d);
        check("R9 any read clears irq", 32'(irq), 32'd0);
        wr(8, 32'h100);
        complete(1, 12'h0D0, 1'b0);
        check("R9 enables ignored", 32'(irq), 32'd1);
        rd(6, d);
        rd(1, d);
        check("R9 cleared after reads", 32'(irq), 32'd0);
    endtask

    task automatic t_write_ignored();
        logic [31:0] d;
        complete(2, 12'h5A5, 1'b0);
        wr(2, 32'hFFFF_FFFF);
        rd(2, d);
        check("R10 data write ignored", d, word(1, 0, 12'h5A5));
        rd(12, d);
        check("R10 unmapped offset reads 0", d, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_boundary();
        t_overrun();
        t_no_overrun();
        t_collide();
        t_enable_reg();
        t_per_channel();
        t_shared();
        t_write_ignored();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule